// File: doc/BRIEF.md
# Dual-Set Sinusoidal PWM Generator

This block drives the six legs of a two-level inverter that feeds a machine with two three-phase stator windings. It builds six sinusoidal references from one phase accumulator and compares each of them against a single triangular carrier. The output is one gate bit per leg, and a 1 turns on the upper switch of that leg. The second three-phase set lags the first by 30 electrical degrees. Inside each set the phases are spaced 120 degrees apart.

The reference frequency is given as a phase-increment word. The modulation index is given as an unsigned fraction. Both can change while the block runs. The block samples them only when the carrier reaches its top, so each carrier period uses one consistent pair of values. With the default parameters the block runs from a 100 MHz clock and makes a carrier near 10.8 kHz. A 50 Hz reference needs an increment of about 2147.

Top module: `dual_spwm`

## Requirements
- R1: While rst_ni is low, gate_o is 0. The carrier restarts at 0 and counts upward, the phase accumulator is 0, and the captured frequency and index are 0.
- R2: The carrier period is P = round(CLK_HZ/CARRIER_HZ) clocks, and the carrier top is PEAK = floor(P/2). The carrier rises by 1 per clock from 0 to PEAK. It then falls by 1 per clock, down to 0 when P is odd or down to 1 when P is even, and then restarts at 0.
- R3: freq_i and mod_i are captured only at the clock edge where the carrier sits at PEAK while rising. Values applied at any other time have no effect until the next such edge.
- R4: The PHASE_W-bit accumulator adds the captured increment on every clock and wraps modulo 2^PHASE_W. The reference frequency is therefore freq_i*CLK_HZ/2^PHASE_W.
- R5: The sine value of a leg depends only on the top QBITS+2 bits of that leg's phase, taken as bin n out of 4*2^QBITS bins. Its value is round((2^(SIN_W-1)-1)*sin(2*pi*(n+0.5)/(4*2^QBITS))), with an error of at most 1.
- R6: The level of a leg is floor(PEAK*(2^(SIN_W-1) + floor(sine*mod/2^MOD_W))/2^SIN_W). Here mod is the captured mod_i, read as an unsigned fraction of 2^MOD_W.
- R7: Each leg's phase is the accumulator minus round(k*2^PHASE_W/12). The values of k are:
  - gate_o[0] (leg a): k = 0
  - gate_o[1] (leg d): k = 1
  - gate_o[2] (leg b): k = 4
  - gate_o[3] (leg e): k = 5
  - gate_o[4] (leg c): k = 8
  - gate_o[5] (leg f): k = 9
- R8: When en_i is high, the gate bit taken at a clock edge is 1 exactly when the leg's level is greater than the carrier value before that edge. The bit appears at gate_o after the edge.
- R9: When en_i is low at a clock edge, all of gate_o is 0 after that edge. The carrier and the accumulator keep running, so re-enabling resumes at the running phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Gate enable |
| freq_i | input | PHASE_W | Phase increment per clock (reference frequency) |
| mod_i | input | MOD_W | Modulation index, unsigned fraction of 2^MOD_W |
| gate_o | output | 6 | Gate bits, leg order a, d, b, e, c, f at bits 0 to 5 |

## Verification
The assertions allow en_i, freq_i and mod_i to change at any clock. They do assume that these inputs settle before the clock edge, and that the parameters give a carrier top of at least 2, so that the rise and the fall are both visible. The stimulus changes every input one time unit after a rising edge. It changes frequency and index in the middle of carrier periods and in the middle of reference periods, so sampling at the carrier top is exercised. It also toggles enable and reset while the carrier and the accumulator are away from zero.

// File: rtl/dual_spwm_pkg.sv
`timescale 1ns/1ps
package dual_spwm_pkg;

  localparam int LEGS = 6;

  // Rounded amp*sin((2*idx+1)*pi/(4*2^qbits)), Q30 Taylor series, elaboration only
  function automatic int quarter_sin(input int idx, input int qbits, input int amp);
    longint pi_q30, x, x2, term, sum;
    pi_q30 = 64'sd3373259426;
    x      = ((2 * longint'(idx) + 1) * pi_q30) / (longint'(4) <<< qbits);
    x2     = (x * x) >>> 30;
    term   = x;
    sum    = x;
    for (int k = 1; k <= 8; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
      sum += term;
    end
    return int'((sum * longint'(amp) + (longint'(1) <<< 29)) >>> 30);
  endfunction

  // Leg order a,d,b,e,c,f -> offset in twelfths of a turn
  function automatic int leg_twelfths(input int leg);
    return (leg / 2) * 4 + (leg % 2);
  endfunction

endpackage

// File: rtl/spwm_carrier.sv
`timescale 1ns/1ps
module spwm_carrier #(
  parameter int PEAK  = 4629,
  parameter int ODD   = 1,
  parameter int CAR_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CAR_W-1:0] cnt_o,
  output logic             peak_o
);

  localparam logic [CAR_W-1:0] TOP    = CAR_W'(PEAK);
  localparam logic [CAR_W-1:0] VALLEY = (ODD != 0) ? '0 : CAR_W'(1);

  logic rising_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      if (cnt_o == TOP) begin
        rising_q <= 1'b0;
        cnt_o    <= TOP - CAR_W'(1);
      end else begin
        cnt_o <= cnt_o + CAR_W'(1);
      end
    end else begin
      // odd period: valley value is held for two clocks
      if (cnt_o == VALLEY) begin
        rising_q <= 1'b1;
        cnt_o    <= '0;
      end else begin
        cnt_o <= cnt_o - CAR_W'(1);
      end
    end
  end

  assign peak_o = rising_q && (cnt_o == TOP);

endmodule

// File: rtl/spwm_phase.sv
`timescale 1ns/1ps
module spwm_phase #(
  parameter int PHASE_W = 32,
  parameter int MOD_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               peak_i,
  input  logic [PHASE_W-1:0] freq_i,
  input  logic [MOD_W-1:0]   mod_i,
  output logic [PHASE_W-1:0] freq_o,
  output logic [MOD_W-1:0]   mod_o,
  output logic [PHASE_W-1:0] acc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o <= '0;
      mod_o  <= '0;
      acc_o  <= '0;
    end else begin
      acc_o <= acc_o + freq_o;
      if (peak_i) begin
        freq_o <= freq_i;
        mod_o  <= mod_i;
      end
    end
  end

endmodule

// File: rtl/spwm_leg.sv
`timescale 1ns/1ps
module spwm_leg #(
  parameter int                PHASE_W = 32,
  parameter int                QBITS   = 8,
  parameter int                SIN_W   = 16,
  parameter int                MOD_W   = 16,
  parameter int                CAR_W   = 13,
  parameter int                PEAK    = 4629,
  parameter logic [PHASE_W-1:0] OFFSET = '0,
  localparam int               QN      = 1 << QBITS
) (
  input  logic [PHASE_W-1:0]           acc_i,
  input  logic [MOD_W-1:0]             mod_i,
  input  logic [CAR_W-1:0]             carrier_i,
  input  logic [QN-1:0][SIN_W-2:0]     qtab_i,
  output logic                         cmp_o
);

  localparam int PW = CAR_W + SIN_W;
  localparam logic [PW-1:0] PEAK_W = PW'(PEAK);

  logic [PHASE_W-1:0]            ph;
  logic [1:0]                    quad;
  logic [QBITS-1:0]              idx, addr;
  logic [SIN_W-2:0]              mag;
  logic signed [SIN_W-1:0]       sine;
  logic signed [SIN_W+MOD_W:0]   prod, shifted;
  logic [SIN_W-1:0]              scaled, biased;
  logic [PW-1:0]                 lvl_full;
  logic [CAR_W-1:0]              lvl;

  always_comb begin
    ph    = acc_i - OFFSET;
    quad  = ph[PHASE_W-1 -: 2];
    idx   = ph[PHASE_W-3 -: QBITS];
    // quadrants 1 and 3 walk the table backwards
    addr  = quad[0] ? ~idx : idx;
    mag   = qtab_i[addr];
    sine  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    prod    = sine * $signed({1'b0, mod_i});
    shifted = prod >>> MOD_W;
    scaled  = shifted[SIN_W-1:0];
    // offset binary: add half scale by flipping the sign bit
    biased   = {~scaled[SIN_W-1], scaled[SIN_W-2:0]};
    lvl_full = PEAK_W * PW'(biased);
    lvl      = lvl_full[PW-1 -: CAR_W];
    cmp_o    = lvl > carrier_i;
  end

endmodule

// File: rtl/dual_spwm.sv
`timescale 1ns/1ps
module dual_spwm #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int CARRIER_HZ = 10_800,
  parameter int PHASE_W    = 32,
  parameter int QBITS      = 8,
  parameter int SIN_W      = 16,
  parameter int MOD_W      = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] freq_i,
  input  logic [MOD_W-1:0]   mod_i,
  output logic [5:0]         gate_o
);

  localparam int LEGS   = dual_spwm_pkg::LEGS;
  localparam int PERIOD = (CLK_HZ + CARRIER_HZ / 2) / CARRIER_HZ;
  localparam int PEAK   = PERIOD / 2;
  localparam int ODD    = PERIOD % 2;
  localparam int CAR_W  = $clog2(PEAK + 1);
  localparam int QN     = 1 << QBITS;
  localparam int AMP    = (1 << (SIN_W - 1)) - 1;

  logic [CAR_W-1:0]          carrier_q;
  logic                      at_peak;
  logic [PHASE_W-1:0]        freq_q;
  logic [MOD_W-1:0]          mod_q;
  logic [PHASE_W-1:0]        acc_q;
  logic [QN-1:0][SIN_W-2:0]  qtab;
  logic [LEGS-1:0]           cmp;
  logic [LEGS-1:0]           gate_q;

  spwm_carrier #(
    .PEAK (PEAK),
    .ODD  (ODD),
    .CAR_W(CAR_W)
  ) i_carrier (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (carrier_q),
    .peak_o(at_peak)
  );

  spwm_phase #(
    .PHASE_W(PHASE_W),
    .MOD_W  (MOD_W)
  ) i_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .peak_i(at_peak),
    .freq_i(freq_i),
    .mod_i (mod_i),
    .freq_o(freq_q),
    .mod_o (mod_q),
    .acc_o (acc_q)
  );

  for (genvar g = 0; g < QN; g++) begin : g_qtab
    assign qtab[g] = (SIN_W-1)'(dual_spwm_pkg::quarter_sin(g, QBITS, AMP));
  end

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    localparam longint OFF_L =
      (longint'(dual_spwm_pkg::leg_twelfths(l)) * (longint'(1) <<< PHASE_W) + 6) / 12;
    spwm_leg #(
      .PHASE_W(PHASE_W),
      .QBITS  (QBITS),
      .SIN_W  (SIN_W),
      .MOD_W  (MOD_W),
      .CAR_W  (CAR_W),
      .PEAK   (PEAK),
      .OFFSET (PHASE_W'(OFF_L))
    ) i_leg (
      .acc_i    (acc_q),
      .mod_i    (mod_q),
      .carrier_i(carrier_q),
      .qtab_i   (qtab),
      .cmp_o    (cmp[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= en_i ? cmp : '0;
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/dual_spwm_chk.sv
`timescale 1ns/1ps
module dual_spwm_chk #(
  parameter int PHASE_W = 32,
  parameter int MOD_W   = 16,
  parameter int CAR_W   = 13,
  parameter int PEAK    = 4629,
  parameter int PERIOD  = 9259
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [5:0]         gate_o,
  input logic [CAR_W-1:0]   carrier,
  input logic               at_peak,
  input logic [PHASE_W-1:0] freq_q,
  input logic [MOD_W-1:0]   mod_q
);

  logic        past_ok;
  logic        seen_peak;
  logic [31:0] per_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok   <= 1'b0;
      seen_peak <= 1'b0;
      per_cnt   <= '0;
    end else begin
      past_ok <= 1'b1;
      if (at_peak) begin
        seen_peak <= 1'b1;
        per_cnt   <= '0;
      end else begin
        per_cnt <= per_cnt + 32'd1;
      end
    end
  end

  // R9
  gates_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(en_i) |-> gate_o == '0);

  // R2
  carrier_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier <= CAR_W'(PEAK));

  // R2
  carrier_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (carrier == $past(carrier) + CAR_W'(1)) ||
                (carrier + CAR_W'(1) == $past(carrier)) ||
                (carrier == '0 && $past(carrier) == '0));

  // R2
  carrier_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_peak && seen_peak |-> per_cnt == 32'(PERIOD - 1));

  // R3
  freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(at_peak) |-> $stable(freq_q));

  // R3
  mod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(at_peak) |-> $stable(mod_q));

endmodule

bind dual_spwm dual_spwm_chk #(
  .PHASE_W(PHASE_W),
  .MOD_W  (MOD_W),
  .CAR_W  (CAR_W),
  .PEAK   (PEAK),
  .PERIOD (PERIOD)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .gate_o (gate_o),
  .carrier(carrier_q),
  .at_peak(at_peak),
  .freq_q (freq_q),
  .mod_q  (mod_q)
);

// File: tb/test_dual_spwm.sv
`timescale 1ns/1ps
module test_dual_spwm;

  localparam int  CLK_HZ = 100_000_000;
  localparam int  CAR_HZ = 497_512;
  localparam int  P      = (CLK_HZ + CAR_HZ / 2) / CAR_HZ;  // 201, odd
  localparam int  PK     = P / 2;
  localparam real PI     = 3.14159265358979323846;
  localparam int  WDOG   = 150_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] freq = '0;
  logic [15:0] mod = '0;
  logic [5:0]  gate;

  int    vectors = 0;
  int    fails = 0;
  int    cyc = 0;
  string req = "R1";

  // reference model state
  logic [31:0] m_acc = '0;
  logic [31:0] m_f = '0;
  logic [15:0] m_m = '0;
  int          m_t = 0;
  logic [5:0]  exp_g = '0;
  logic [5:0]  care = '1;

  always #10 clk = ~clk;

  dual_spwm #(
    .CLK_HZ    (CLK_HZ),
    .CARRIER_HZ(CAR_HZ)
  ) i_dual_spwm (
    .clk_i (clk),
    .rst_ni(rst_n),
    .en_i  (en),
    .freq_i(freq),
    .mod_i (mod),
    .gate_o(gate)
  );

  function automatic int twelfths(input int leg);
    return (leg / 2) * 4 + (leg % 2);  // R7 leg order a,d,b,e,c,f
  endfunction

  always @(negedge clk) begin
    cyc++;
    vectors++;
    if (!rst_n) begin
      // R1
      if (gate !== 6'b0) begin
        fails++;
        $display("FAIL R1 cycle %0d gate_o=%b expected=000000", cyc, gate);
      end
      m_acc = '0; m_f = '0; m_m = '0; m_t = 0;
      exp_g = '0; care = '1;
    end else begin
      if ($isunknown(gate) || (((gate ^ exp_g) & care) != 6'b0)) begin
        fails++;
        $display("FAIL %s cycle %0d gate_o=%b expected=%b mask=%b", req, cyc, gate, exp_g, care);
      end
      begin
        int  car;
        car = (m_t <= PK) ? m_t : 2 * PK - m_t;  // R2
        for (int l = 0; l < 6; l++) begin
          logic [31:0] off, p;
          int          bin;
          real         ang, lvl;
          off = 32'((longint'(twelfths(l)) * (longint'(1) << 32) + 6) / 12);
          p   = m_acc - off;                     // R4, R7
          bin = int'(p >> 22);
          ang = 2.0 * PI * (real'(bin) + 0.5) / 1024.0;   // R5
          lvl = real'(PK) * (0.5 + 0.5 * (real'(m_m) / 65536.0) *
                (32767.0 / 32768.0) * $sin(ang));          // R6
          if (!en) begin                         // R9
            exp_g[l] = 1'b0; care[l] = 1'b1;
          end else begin                         // R8
            exp_g[l] = lvl > real'(car) + 1.5;
            care[l]  = (lvl >= real'(car) + 2.1) || (lvl <= real'(car) + 0.9);
          end
        end
        m_acc = m_acc + m_f;
        if (m_t == PK) begin                     // R3
          m_f = freq;
          m_m = mod;
        end
        m_t = (m_t + 1) % P;
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    run(5);
    rst_n = 1'b1;
    // R9: disabled while captures happen
    req = "R9"; freq = 32'd214748; mod = 16'd18022;
    run(600);
    // R8, R5, R6, R7: index 0.275
    req = "R8"; en = 1'b1;
    run(30_037);
    // R3, R4: mid-period change of frequency and index (0.481)
    req = "R3"; freq = 32'd268435; mod = 16'd31523;
    run(30_011);
    // R9: disable with counters running
    req = "R9"; en = 1'b0;
    run(413);
    // R6: near full index, higher frequency
    req = "R6"; en = 1'b1; mod = 16'hFFFF; freq = 32'd429497;
    run(25_003);
    // R1: reset mid-run
    req = "R1"; rst_n = 1'b0;
    run(5);
    rst_n = 1'b1;
    // R2: zero index, carrier shape alone
    req = "R2"; freq = '0; mod = '0;
    run(2_000);
    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 cycle %0d actual=running expected=finished", cyc);
    finish_run();
  end

endmodule